// File: doc/BRIEF.md
# Byte-wide SPI controller with master fallback

This block is a single-byte SPI port that can run as either side of the link. Software configures it through an 8-bit control register on a small register bus. It then places a byte in the data register. In master mode that write starts an exchange. The block lowers its select output, drives the serial clock from a divided system clock and shifts eight bits each way. In slave mode it follows the external clock and select pins, and a data write only preloads the byte to be returned.

All four combinations of clock polarity and phase are supported, and either bit order can be chosen. At the end of every byte the received value replaces the data register contents and a sticky completion flag is set. If another device pulls the select input low while the block is master, hardware clears the master bit, so the block falls back to slave and stops driving the clock.

Top module: `spi_ctl`

## Requirements
- R1: Three registers are at bus offsets 0 (control), 1 (status: bit 7 transfer done, bit 6 write collision, other bits 0) and 2 (data). Control bits are 7 clock-double, 6 enable, 5 LSB-first, 4 master, 3:2 mode, 1:0 prescaler. Every control bit reads back as written, and after reset all three registers read 0x00.
- R2: With enable at 0, a data write starts no exchange: ss_n_o stays 1, sck_oe and miso_oe stay 0 and the done flag stays 0.
- R3: With enable and master at 1, a data write when the port is idle holds ss_n_o low for one 8-bit exchange. When the exchange ends, the byte sampled from miso_i is in the data register and status bit 7 is 1.
- R4: With LSB-first at 1, bit 0 of the byte goes out and comes in first. With LSB-first at 0, bit 7 goes first.
- R5: Mode bit 3 is the idle level of SCK, and mode bit 2 set means data is sampled on the trailing edge instead of the leading edge. The other edge of each pair shifts data out, and SCK returns to idle at the end of the byte.
- R6: In master mode each SCK half period lasts 2, 8, 32 or 64 system clocks for prescaler codes 0 to 3. Clock-double at 1 halves each of these.
- R7: While enable and master are 1, ss_n_i low clears the master bit. The other control bits are kept, and the port stops driving SCK.
- R8: In slave mode the block shifts mosi_i in and miso_o out on the edges of sck_i chosen by the mode. It stores the byte and sets the done flag after the eighth trailing edge. miso_oe is 1 only while ss_n_i is low.
- R9: In slave mode, raising ss_n_i before the eighth trailing edge discards the partial byte: no flag is set and the next full byte is received correctly.
- R10: A data write during an exchange is ignored: the byte on the line and the byte stored at the end are unchanged. The write also sets status bit 6.
- R11: The flags clear only when the status register is read with a flag set and the data register is read afterwards. A data read without that earlier status read leaves them set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears flags in sequence) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| sck_i | input | 1 | Serial clock from a remote master |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Drive enable for sck_o |
| ss_n_i | input | 1 | Select input, active low |
| ss_n_o | output | 1 | Select output, low during a master exchange |
| mosi_i | input | 1 | Serial data in for slave mode |
| mosi_o | output | 1 | Serial data out in master mode |
| miso_i | input | 1 | Serial data in for master mode |
| miso_o | output | 1 | Serial data out in slave mode |
| miso_oe | output | 1 | Drive enable for miso_o |

## Verification
The first result of a master exchange appears one clock after the data write, when ss_n_o goes low. The first SCK edge follows after one half period, and the done flag rises one clock after the sixteenth edge. The bench therefore measures half periods between consecutive sck_o changes and polls status for the end instead of assuming one fixed delay. In slave mode every input passes through a two-stage synchronizer and an edge detector, so each effect arrives three clocks after the pin changes. The bench drives half periods of eight clocks and checks miso_o, flags and data only after those stages have settled. Every bus read is sampled while its strobe is held, before the clock edge that acts on it.

// File: rtl/spi_pkg.sv
package spi_pkg;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_STAT = 2'd1,
    A_DATA = 2'd2
  } reg_addr_e;

  typedef struct packed {
    logic       dbl;
    logic       en;
    logic       lsb_first;
    logic       master;
    logic [1:0] mode;
    logic [1:0] presc;
  } ctrl_t;

  // log2 of the SCK half period in system clocks
  function automatic logic [2:0] half_log2(input logic [1:0] presc, input logic dbl);
    logic [2:0] b;
    case (presc)
      2'd0:    b = 3'd1;
      2'd1:    b = 3'd3;
      2'd2:    b = 3'd5;
      default: b = 3'd6;
    endcase
    return b - {2'b00, dbl};
  endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s0_q, s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q <= RST_VAL;
      s1_q <= RST_VAL;
    end else begin
      s0_q <= d_i;
      s1_q <= s0_q;
    end
  end

  assign q_o = s1_q;
endmodule

// File: rtl/spi_sckgen.sv
module spi_sckgen #(
  parameter int DIV_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       end_i,
  input  logic       cpol_i,
  input  logic [2:0] half_log2_i,
  output logic       busy_o,
  output logic       sck_o,
  output logic       edge_o,
  output logic       lead_o
);
  logic [DIV_W-1:0] cnt_q, cnt_n, half_m1;
  logic [DIV_W:0]   span;
  logic             busy_q, busy_n, sck_q, sck_n, tick;

  always_comb begin
    span    = (DIV_W+1)'(1) << half_log2_i;
    half_m1 = span[DIV_W-1:0] - DIV_W'(1);
  end

  assign tick   = busy_q && (cnt_q == half_m1);
  assign edge_o = tick;
  assign lead_o = (sck_q == cpol_i);
  assign busy_o = busy_q;
  assign sck_o  = busy_q ? sck_q : cpol_i;

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    sck_n  = sck_q;
    if (stop_i) begin
      busy_n = 1'b0;
      cnt_n  = '0;
      sck_n  = cpol_i;
    end else if (!busy_q) begin
      cnt_n  = '0;
      sck_n  = cpol_i;
      busy_n = start_i;
    end else begin
      if (tick) begin
        cnt_n = '0;
        sck_n = ~sck_q;
      end else begin
        cnt_n = cnt_q + DIV_W'(1);
      end
      if (end_i) busy_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sck_q  <= 1'b0;
    end else begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
      sck_q  <= sck_n;
    end
  end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              edge_i,
  input  logic              lead_i,
  input  logic              in_bit_i,
  input  logic              cpha_i,
  input  logic              lsb_i,
  output logic              out_bit_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_o
);
  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] tx_q, tx_n, rx_q, rx_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              samp, setp, trail;

  assign samp      = edge_i & (lead_i ^ cpha_i);
  assign setp      = edge_i & ~(lead_i ^ cpha_i);
  assign trail     = edge_i & ~lead_i;
  assign done_o    = ~clr_i & trail & (cnt_q == LAST);
  assign out_bit_o = lsb_i ? tx_q[0] : tx_q[DATA_W-1];
  assign rx_o      = rx_n;

  always_comb begin
    tx_n  = tx_q;
    rx_n  = rx_q;
    cnt_n = cnt_q;
    if (clr_i) begin
      cnt_n = '0;
    end else begin
      if (samp)
        rx_n = lsb_i ? {in_bit_i, rx_q[DATA_W-1:1]} : {rx_q[DATA_W-2:0], in_bit_i};
      // with late sampling the first leading edge only presents bit 0
      if (setp && !(cpha_i && cnt_q == '0))
        tx_n = lsb_i ? {1'b0, tx_q[DATA_W-1:1]} : {tx_q[DATA_W-2:0], 1'b0};
      if (trail) cnt_n = (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
    end
    if (load_i) tx_n = load_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      rx_q  <= '0;
      cnt_q <= '0;
    end else begin
      tx_q  <= tx_n;
      rx_q  <= rx_n;
      cnt_q <= cnt_n;
    end
  end
endmodule

// File: rtl/spi_ctl.sv
module spi_ctl
  import spi_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              ss_n_i,
  output logic              ss_n_o,
  input  logic              mosi_i,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe
);
  logic [1:0]        rst_q;
  logic              rst_s;
  ctrl_t             ctrl_q, ctrl_n;
  logic [DATA_W-1:0] data_q, data_n, rx;
  logic              if_q, if_n, wcol_q, wcol_n, arm_q, arm_n;
  logic              ss_s, sck_s, mosi_s, sck_p;
  logic              mst, s_act, fault, busy, wr_data, rd_data, rd_stat;
  logic              m_busy, m_sck, m_edge, m_lead, done, out_bit;
  logic              e_edge, e_lead, e_in, e_clr;

  // reset asserted at once, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_s = rst_q[1];

  spi_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_s),
    .d_i({ss_n_i, sck_i, mosi_i}), .q_o({ss_s, sck_s, mosi_s})
  );

  assign mst     = ctrl_q.en & ctrl_q.master;
  assign s_act   = ctrl_q.en & ~ctrl_q.master & ~ss_s;
  assign fault   = mst & ~ss_s;
  assign busy    = m_busy | s_act;
  assign wr_data = reg_wr & (reg_addr == A_DATA);
  assign rd_data = reg_rd & (reg_addr == A_DATA);
  assign rd_stat = reg_rd & (reg_addr == A_STAT);

  spi_sckgen #(.DIV_W(DIV_W)) u_sckgen (
    .clk(clk), .rst_n(rst_s),
    .start_i(wr_data & ~fault), .stop_i(~mst), .end_i(done & mst),
    .cpol_i(ctrl_q.mode[1]), .half_log2_i(half_log2(ctrl_q.presc, ctrl_q.dbl)),
    .busy_o(m_busy), .sck_o(m_sck), .edge_o(m_edge), .lead_o(m_lead)
  );

  assign e_edge = mst ? m_edge : (s_act & (sck_s != sck_p));
  assign e_lead = mst ? m_lead : (sck_s != ctrl_q.mode[1]);
  assign e_in   = mst ? miso_i : mosi_s;
  assign e_clr  = mst ? ~m_busy : ~s_act;

  spi_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_s), .clr_i(e_clr),
    .load_i(wr_data & ~busy), .load_data_i(reg_wdata),
    .edge_i(e_edge), .lead_i(e_lead), .in_bit_i(e_in),
    .cpha_i(ctrl_q.mode[0]), .lsb_i(ctrl_q.lsb_first),
    .out_bit_o(out_bit), .done_o(done), .rx_o(rx)
  );

  always_comb begin
    ctrl_n = ctrl_q;
    if (reg_wr && reg_addr == A_CTRL) ctrl_n = ctrl_t'(reg_wdata);
    if (fault) ctrl_n.master = 1'b0;

    data_n = data_q;
    if (wr_data && !busy) data_n = reg_wdata;
    if (done)             data_n = rx;

    if_n   = if_q;
    wcol_n = wcol_q;
    arm_n  = arm_q;
    if (rd_stat && (if_q || wcol_q)) arm_n = 1'b1;
    if (rd_data) begin
      arm_n = 1'b0;
      if (arm_q) begin
        if_n   = 1'b0;
        wcol_n = 1'b0;
      end
    end
    if (done)            if_n   = 1'b1;
    if (wr_data && busy) wcol_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ctrl_q <= '0;
      data_q <= '0;
      if_q   <= 1'b0;
      wcol_q <= 1'b0;
      arm_q  <= 1'b0;
      sck_p  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      data_q <= data_n;
      if_q   <= if_n;
      wcol_q <= wcol_n;
      arm_q  <= arm_n;
      sck_p  <= sck_s;
    end
  end

  always_comb begin
    case (reg_addr_e'(reg_addr))
      A_CTRL:  reg_rdata = ctrl_q;
      A_STAT:  reg_rdata = {if_q, wcol_q, {(DATA_W-2){1'b0}}};
      A_DATA:  reg_rdata = data_q;
      default: reg_rdata = '0;
    endcase
  end

  assign sck_o   = mst ? m_sck : ctrl_q.mode[1];
  assign sck_oe  = mst;
  assign ss_n_o  = ~(mst & m_busy);
  assign mosi_o  = mst & out_bit;
  assign miso_o  = out_bit;
  assign miso_oe = s_act;
endmodule

// File: rtl/spi_ctl_chk.sv
module spi_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ctrl,
  input logic       if_q,
  input logic       wcol_q,
  input logic       busy,
  input logic       ss_s,
  input logic       sck_o,
  input logic       sck_oe,
  input logic       ss_n_o,
  input logic       miso_oe,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic [1:0] reg_addr
);
  a_r2_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[6] |-> (ss_n_o && !sck_oe && !miso_oe));

  a_r3_select_only_master: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_n_o |-> (ctrl[6] && ctrl[4]));

  a_r5_idle_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[6] && ctrl[4] && $rose(ss_n_o)) |-> (sck_o == ctrl[3]));

  a_r7_fault_drops_master: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[6] && ctrl[4] && !ss_s) |=> !ctrl[4]);

  a_r8_miso_released: assert property (@(posedge clk) disable iff (!rst_n)
    ss_s |-> !miso_oe);

  a_r10_collision_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == 2'd2) |=> wcol_q);

  a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (if_q && !reg_rd) |=> if_q);
endmodule

bind spi_ctl spi_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_s), .ctrl(ctrl_q), .if_q(if_q), .wcol_q(wcol_q),
  .busy(busy), .ss_s(ss_s), .sck_o(sck_o), .sck_oe(sck_oe), .ss_n_o(ss_n_o),
  .miso_oe(miso_oe), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr)
);

// File: tb/spi_ctl_tb.sv
`timescale 1ns/1ps
module spi_ctl_tb;
  logic       clk, rst_n;
  logic [1:0] reg_addr;
  logic       reg_wr, reg_rd;
  logic [7:0] reg_wdata, reg_rdata;
  logic       sck_i, sck_o, sck_oe, ss_n_i, ss_n_o;
  logic       mosi_i, mosi_o, miso_i, miso_o, miso_oe;
  int         checks = 0, errors = 0;
  bit         finished = 0;

  spi_ctl u_dut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int exp_half(input logic [1:0] p, input logic dbl);
    int base;
    case (p) 2'd0: base = 2; 2'd1: base = 8; 2'd2: base = 32; default: base = 64; endcase
    return dbl ? base / 2 : base;
  endfunction

  // index of the k-th bit on the wire
  function automatic int wire_idx(input int k, input logic lsb);
    return lsb ? k : 7 - k;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic clear_flags();
    logic [7:0] t;
    rd(2'd1, t);
    rd(2'd2, t);
  endtask

  task automatic wait_flag(input string req);
    logic [7:0] s;
    int n;
    s = 8'h00; n = 0;
    while (s[7] == 1'b0 && n < 6000) begin
      rd(2'd1, s);
      n++;
    end
    chk(req, {31'd0, s[7]}, 32'd1);
  endtask

  // remote slave answering the DUT as master
  task automatic peer_slave(input logic [7:0] sb, input logic cpha, input logic lsb,
                            output logic [7:0] got);
    got = 8'h00;
    miso_i = sb[wire_idx(0, lsb)];
    wait (ss_n_o == 1'b0);
    for (int e = 0; e < 16; e++) begin
      @(sck_o);
      if (((e % 2) == 0) ^ cpha) begin
        got[wire_idx(e / 2, lsb)] = mosi_o;
      end else begin
        int bi;
        bi = cpha ? e / 2 : e / 2 + 1;
        if (bi < 8) miso_i = sb[wire_idx(bi, lsb)];
      end
    end
  endtask

  task automatic master_xfer(input logic [7:0] ctrl, input logic [7:0] tx,
                             input logic [7:0] sb, input string req);
    logic [7:0] got, d;
    wr(2'd0, ctrl);
    clear_flags();
    fork
      peer_slave(sb, ctrl[2], ctrl[5], got);
      begin wr(2'd2, tx); wait_flag({req, " done flag"}); end
    join
    chk({req, " mosi byte"}, {24'd0, got}, {24'd0, tx});
    rd(2'd2, d);
    chk({req, " data register"}, {24'd0, d}, {24'd0, sb});
  endtask

  // remote master driving the DUT as slave, half period 8 clocks
  task automatic drive_slave(input logic [7:0] mb, input logic cpha, input logic lsb,
                             input int nbits, output logic [7:0] got);
    got = 8'h00;
    @(negedge clk);
    ss_n_i = 1'b0;
    mosi_i = mb[wire_idx(0, lsb)];
    repeat (8) @(negedge clk);
    for (int e = 0; e < 2 * nbits; e++) begin
      if (((e % 2) == 0) ^ cpha) begin
        got[wire_idx(e / 2, lsb)] = miso_o;
      end else begin
        int bi;
        bi = cpha ? e / 2 : e / 2 + 1;
        if (bi < 8) mosi_i = mb[wire_idx(bi, lsb)];
      end
      sck_i = ~sck_i;
      repeat (8) @(negedge clk);
    end
    ss_n_i = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic slave_xfer(input logic [7:0] ctrl, input logic [7:0] mb,
                            input logic [7:0] tx, input string req);
    logic [7:0] got, s, d;
    sck_i = ctrl[3];
    wr(2'd0, ctrl);
    clear_flags();
    wr(2'd2, tx);
    drive_slave(mb, ctrl[2], ctrl[5], 8, got);
    chk({req, " miso byte"}, {24'd0, got}, {24'd0, tx});
    rd(2'd1, s);
    chk({req, " done flag"}, {31'd0, s[7]}, 32'd1);
    rd(2'd2, d);
    chk({req, " data register"}, {24'd0, d}, {24'd0, mb});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, s, got, tx, sb;
    realtime t0, t1;
    void'($urandom(32'd20240611));
    reg_addr = 2'd0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = 8'h00;
    sck_i = 1'b0; ss_n_i = 1'b1; mosi_i = 1'b0; miso_i = 1'b0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values and control read-back
    rd(2'd0, d); chk("R1 ctrl reset", {24'd0, d}, 32'h00);
    rd(2'd1, d); chk("R1 status reset", {24'd0, d}, 32'h00);
    rd(2'd2, d); chk("R1 data reset", {24'd0, d}, 32'h00);
    chk("R1 pins at reset", {29'd0, ss_n_o, sck_oe, miso_oe}, 32'h4);
    wr(2'd0, 8'hAF); rd(2'd0, d); chk("R1 ctrl readback", {24'd0, d}, 32'hAF);

    // R2 disabled port ignores a data write
    wr(2'd0, 8'h10);
    wr(2'd2, 8'h3C);
    repeat (40) begin
      @(negedge clk);
      if (ss_n_o !== 1'b1 || sck_oe !== 1'b0) begin
        chk("R2 no exchange", {30'd0, ss_n_o, sck_oe}, 32'h2);
        break;
      end
    end
    rd(2'd1, s); chk("R2 no done flag", {24'd0, s}, 32'h00);
    chk("R2 miso released", {31'd0, miso_oe}, 32'd0);

    // R3 R4 R5 directed: every mode with both bit orders
    for (int m = 0; m < 4; m++) begin
      master_xfer(8'h50 | 8'(m << 2), 8'hA1, 8'h3E, "R3 R5 msb-first");
      master_xfer(8'h70 | 8'(m << 2), 8'hC4, 8'h2B, "R4 R5 lsb-first");
      chk("R5 sck idle level", {31'd0, sck_o}, {31'd0, 1'(m >> 1)});
    end

    // R6 half period for every prescaler and clock-double setting
    for (int c = 0; c < 8; c++) begin
      wr(2'd0, 8'h50 | 8'(c & 3) | (c >= 4 ? 8'h80 : 8'h00));
      clear_flags();
      fork
        begin @(sck_o); t0 = $realtime; @(sck_o); t1 = $realtime; end
        begin wr(2'd2, 8'h55); wait_flag("R6 done"); end
      join
      chk("R6 half period", 32'($rtoi((t1 - t0) / 5.0)),
          32'(exp_half(2'(c & 3), c >= 4)));
    end

    // R11 flag clearing order
    wr(2'd0, 8'hD0);
    clear_flags();
    fork
      peer_slave(8'h96, 1'b0, 1'b0, got);
      wr(2'd2, 8'h11);
    join
    repeat (10) @(negedge clk);
    rd(2'd2, d); chk("R11 data", {24'd0, d}, 32'h96);
    rd(2'd1, s); chk("R11 data read alone keeps flag", {24'd0, s}, 32'h80);
    rd(2'd2, d);
    rd(2'd1, s); chk("R11 status then data clears", {24'd0, s}, 32'h00);

    // R10 write collision
    wr(2'd0, 8'h53);
    clear_flags();
    fork
      peer_slave(8'h6D, 1'b0, 1'b0, got);
      begin
        wr(2'd2, 8'hE2);
        repeat (100) @(negedge clk);
        wr(2'd2, 8'h5A);
        wait_flag("R10 done");
      end
    join
    rd(2'd1, s); chk("R10 collision flag", {31'd0, s[6]}, 32'd1);
    chk("R10 line byte unchanged", {24'd0, got}, 32'hE2);
    rd(2'd2, d); chk("R10 stored byte unchanged", {24'd0, d}, 32'h6D);

    // R7 mode fault
    wr(2'd0, 8'hD5);
    ss_n_i = 1'b0;
    repeat (5) @(negedge clk);
    rd(2'd0, d); chk("R7 master cleared", {24'd0, d}, 32'hC5);
    chk("R7 sck released", {31'd0, sck_oe}, 32'd0);
    ss_n_i = 1'b1;
    repeat (4) @(negedge clk);

    // R8 miso drive follows select
    wr(2'd0, 8'h40);
    chk("R8 miso off with select high", {31'd0, miso_oe}, 32'd0);
    ss_n_i = 1'b0; repeat (4) @(negedge clk);
    chk("R8 miso on with select low", {31'd0, miso_oe}, 32'd1);
    ss_n_i = 1'b1; repeat (4) @(negedge clk);
    chk("R8 miso off again", {31'd0, miso_oe}, 32'd0);

    // R8 slave exchanges in every mode
    for (int m = 0; m < 4; m++)
      slave_xfer(8'h40 | 8'(m << 2) | (m[0] ? 8'h20 : 8'h00), 8'h8B, 8'h74, "R8 slave");

    // R9 partial byte discarded
    sck_i = 1'b0;
    wr(2'd0, 8'h40);
    clear_flags();
    wr(2'd2, 8'h0F);
    drive_slave(8'hF3, 1'b0, 1'b0, 3, got);
    rd(2'd1, s); chk("R9 no flag after partial", {24'd0, s}, 32'h00);
    rd(2'd2, d); chk("R9 data untouched", {24'd0, d}, 32'h0F);
    slave_xfer(8'h40, 8'h5C, 8'h99, "R9 next byte");

    // random master exchanges (R3 R4 R5)
    for (int i = 0; i < 10; i++) begin
      logic [7:0] cfg;
      cfg = (8'($urandom) & 8'hAD) | 8'h50;
      tx = 8'($urandom); sb = 8'($urandom);
      master_xfer(cfg & 8'hFE, tx, sb, "R3 R4 random master");
    end
    // random slave exchanges (R8)
    for (int i = 0; i < 6; i++) begin
      logic [7:0] cfg;
      cfg = (8'($urandom) & 8'h2C) | 8'h40;
      tx = 8'($urandom); sb = 8'($urandom);
      slave_xfer(cfg, sb, tx, "R8 random slave");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule